// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Power-of-Two Clock Divider

This block runs one full-duplex byte exchange with an SPI slave per request. The host presents a byte and the mode inputs, then pulses a start strobe. The block lowers its slave-select line and produces sixteen serial-clock edges. It shifts the host byte out on MOSI and assembles the byte arriving on MISO. It then raises slave select, pulses a one-cycle completion flag and holds the received byte on a read-data output until the next exchange finishes.

The serial clock is derived from the system clock. A 3-bit rate select `s` gives a half period of 2^s system clocks, so one SCK period is 2^(s+1) clocks (ratios 2 through 256). The divider only counts while an exchange is running and is held cleared otherwise. Idle polarity, sampling phase and bit order are picked per exchange. A fixed envelope of half periods surrounds the clock edges: a lead before the first edge, a lag after the last edge, and a minimum deselected gap before the next exchange.

Top module: `spi_xfer_master`

## Requirements
- R1: With half period H = 2^rate_sel, the SCK edges of an exchange occur H, 2H, ..., 16H system clocks after the clock edge that accepts the start. That makes 16 edges in all, which is 8 full SCK periods.
- R2: The divider is held cleared while idle, so every exchange has the same timing. busy_o is high for exactly 18·H cycles per exchange.
- R3: An exchange shifts exactly eight bits each way. When it completes, rdata_o holds the eight MISO bits received, and the slave has received the byte that was on wdata_i at the start.
- R4: SCK idles at the level of cpol_i (0 low, 1 high) and toggles only on the sixteen edges. With cpol_i=1 the same edges toggle, from the opposite starting level.
- R5: With cpha_i=0, MOSI carries the first bit from the cycle of acceptance. MISO is sampled on odd edges (1, 3, .., 15), and MOSI moves to the next bit on edges 2, 4, .., 14. With cpha_i=1, MOSI presents bit k on edge 2k+1 and MISO is sampled on even edges (2, 4, .., 16).
- R6: With lsb_first_i=0, bit 7 moves first and bit 0 last. With lsb_first_i=1, bit 0 moves first. The same order applies to both MOSI and MISO.
- R7: ss_n_o goes low on the cycle of acceptance, a half period before edge 1. It goes high again H cycles after edge 16, in the same cycle that done_o pulses.
- R8: After ss_n_o rises, busy_o stays high for H more cycles with no SCK edge, so slave select stays high for at least H cycles between exchanges.
- R9: A start pulse while busy_o is high is ignored: the running exchange continues unchanged and no second exchange is queued.
- R10: wdata_i, rate_sel_i, cpha_i, cpol_i and lsb_first_i are captured at acceptance. Changing them during an exchange has no effect on it.
- R11: done_o is high for exactly one system clock per exchange. rdata_o carries the new byte from that cycle on and keeps it until the next completion.
- R12: After reset, SCK sits at the cpol_i level, ss_n_o is high, MOSI is low, busy_o and done_o are low and rdata_o is zero.
- R13: MOSI is low whenever no data bit is being presented: while idle, before edge 1 with cpha_i=1, and from the cycle of done_o onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an exchange; accepted only while idle |
| wdata_i | input | 8 | Byte to transmit, captured at acceptance |
| rate_sel_i | input | 3 | Half period of SCK is 2^rate_sel_i system clocks |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Sampling phase: 0 samples on odd edges, 1 on even edges |
| lsb_first_i | input | 1 | 1 sends and receives bit 0 first |
| miso_i | input | 1 | Serial data from the slave |
| rdata_o | output | 8 | Last byte received, updated with done_o |
| busy_o | output | 1 | Exchange in progress, including lead, lag and gap |
| done_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 1 | Active-low slave select |

## Verification
The bench compares every port against a behavioural model on every clock. A wrong phase count therefore shows up in SCK, MOSI or ss_n_o within one half period of the slip. A divider that is not cleared between exchanges moves the first SCK edge of the next exchange and is caught before that edge lands. A wrong bit index in the shift register stays invisible until a sampling edge. At the done pulse it shows as a mismatch between rdata_o and the slave byte, or between the model slave's assembled byte and the written byte. Mode inputs toggled mid-exchange and start pulses while busy would show as a timing or data mismatch within the same exchange.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // Per-exchange settings held after acceptance
  typedef struct packed {
    logic cpha;
    logic lsb_first;
  } spi_mode_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter  int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;

  // terminal count 2^sel - 1 is a thermometer of sel ones
  for (genvar i = 0; i < CNT_W; i++) begin : g_lim
    assign lim[i] = (int'(sel_i) > i);
  end

  assign tick_o = en_i && (cnt_q == lim);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_xfer_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int EDGES  = 2 * DATA_W,
  localparam int PH_FIN = EDGES + 1,
  localparam int PH_END = EDGES + 2,
  localparam int PH_W   = $clog2(PH_END + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic tick_i,
  output logic busy_o,
  output logic ss_n_o,
  output logic sck_o,
  output logic accept_o,
  output logic sample_o,
  output logic change_o,
  output logic finish_o
);

  seq_state_t      state_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;
  logic            ss_n_q;
  logic            sck_q;
  logic            run;
  logic            edge_en;
  logic            odd;

  assign run      = (state_q == SEQ_RUN);
  assign ph_nxt   = ph_q + 1'b1;
  assign odd      = ph_nxt[0];
  assign edge_en  = run && tick_i && (ph_q < PH_W'(EDGES));
  assign accept_o = !run && start_i;

  always_comb begin
    sample_o = 1'b0;
    change_o = 1'b0;
    if (edge_en) begin
      if (cpha_i) begin
        sample_o = !odd;
        change_o = odd;
      end else begin
        sample_o = odd;
        change_o = !odd && (ph_nxt != PH_W'(EDGES));
      end
    end
  end

  assign finish_o = run && tick_i && (ph_nxt == PH_W'(PH_FIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      ss_n_q  <= 1'b1;
      sck_q   <= cpol_i;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          sck_q <= cpol_i;
          if (start_i) begin
            state_q <= SEQ_RUN;
            ph_q    <= '0;
            ss_n_q  <= 1'b0;
          end
        end
        default: begin
          if (tick_i) begin
            ph_q <= ph_nxt;
            if (edge_en) begin
              sck_q <= ~sck_q;
            end
            if (ph_nxt == PH_W'(PH_FIN)) begin
              ss_n_q <= 1'b1;
            end
            if (ph_nxt == PH_W'(PH_END)) begin
              state_q <= SEQ_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign busy_o = run;
  assign ss_n_o = ss_n_q;
  assign sck_o  = sck_q;

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter  int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int IDX_W  = BIT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cpha_i,
  input  logic              lsbf_i,
  input  logic              order_i,
  input  logic              change_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [IDX_W-1:0]  oi_q;
  logic [IDX_W-1:0]  si_q;
  logic              mosi_q;
  logic [BIT_W-1:0]  out_pos;
  logic [BIT_W-1:0]  in_pos;
  logic [BIT_W-1:0]  first_pos;

  localparam logic [BIT_W-1:0] TOP_POS = BIT_W'(DATA_W - 1);

  assign out_pos   = order_i ? oi_q[BIT_W-1:0] : TOP_POS - oi_q[BIT_W-1:0];
  assign in_pos    = order_i ? si_q[BIT_W-1:0] : TOP_POS - si_q[BIT_W-1:0];
  assign first_pos = lsbf_i ? '0 : TOP_POS;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      oi_q   <= '0;
      si_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= data_i;
      rx_q <= '0;
      si_q <= '0;
      if (cpha_i) begin
        mosi_q <= 1'b0;
        oi_q   <= '0;
      end else begin
        mosi_q <= data_i[first_pos];
        oi_q   <= IDX_W'(1);
      end
    end else begin
      if (change_i) begin
        mosi_q <= tx_q[out_pos];
        oi_q   <= oi_q + 1'b1;
      end
      if (sample_i) begin
        rx_q[in_pos] <= miso_i;
        si_q         <= si_q + 1'b1;
      end
      if (finish_i) begin
        mosi_q <= 1'b0;
      end
    end
  end

  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int SEL_W  = 3,
  localparam int HALF_W = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  rate_sel_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_n_o
);

  spi_mode_t         cfg_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rx;
  logic [HALF_W-1:0] div_cnt;
  logic              tick;
  logic              busy;
  logic              accept;
  logic              sample;
  logic              change;
  logic              finish;

  spi_rate_div #(.SEL_W(SEL_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .en_i   (busy),
    .sel_i  (sel_q),
    .tick_o (tick),
    .cnt_o  (div_cnt)
  );

  spi_seq_ctrl #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cpol_i   (cpol_i),
    .cpha_i   (cfg_q.cpha),
    .tick_i   (tick),
    .busy_o   (busy),
    .ss_n_o   (ss_n_o),
    .sck_o    (sck_o),
    .accept_o (accept),
    .sample_o (sample),
    .change_o (change),
    .finish_o (finish)
  );

  spi_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept),
    .data_i   (wdata_i),
    .cpha_i   (cpha_i),
    .lsbf_i   (lsb_first_i),
    .order_i  (cfg_q.lsb_first),
    .change_i (change),
    .sample_i (sample),
    .finish_i (finish),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .rx_o     (rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        cfg_q.cpha      <= cpha_i;
        cfg_q.lsb_first <= lsb_first_i;
        sel_q           <= rate_sel_i;
      end
      if (finish) begin
        rdata_q <= rx;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;
  assign busy_o  = busy;

endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             done_o,
  input logic             ss_n_o,
  input logic             sck_o,
  input logic [CNT_W-1:0] div_cnt,
  input logic [1:0]       mode_bits
);

  AST_DIV_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (div_cnt == '0)); // R2

  AST_SELECT_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ss_n_o |-> busy_o); // R7

  AST_LEAD_FROM_FIRST_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !ss_n_o); // R7

  AST_DONE_WITH_DESELECT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ss_n_o && busy_o)); // R7

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11

  AST_GAP_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ss_n_o && $past(busy_o)) |-> $stable(sck_o)); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mode_bits)); // R10

endmodule

bind spi_xfer_master spi_xfer_master_chk #(.CNT_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ss_n_o    (ss_n_o),
  .sck_o     (sck_o),
  .div_cnt   (div_cnt),
  .mode_bits (cfg_q)
);

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [2:0] rate_sel_i = 3'd0;
  logic       cpol_i = 1'b0;
  logic       cpha_i = 1'b0;
  logic       lsb_first_i = 1'b0;
  logic       miso_i = 1'b0;
  logic [7:0] rdata_o;
  logic       busy_o, done_o, sck_o, mosi_o, ss_n_o;

  spi_xfer_master u_spi_xfer_master (
    .clk(clk), .rst(rst), .start_i(start_i), .wdata_i(wdata_i),
    .rate_sel_i(rate_sel_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .lsb_first_i(lsb_first_i), .miso_i(miso_i), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o), .sck_o(sck_o), .mosi_o(mosi_o),
    .ss_n_o(ss_n_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int bpos(input int i, input bit lsbf);
    return lsbf ? i : 7 - i;
  endfunction

  // behavioural reference
  bit       m_busy = 0;
  int       m_cnt = 0, m_h = 1, m_s = 0, m_oi = 0, m_sel = 0;
  bit       m_cpha = 0, m_lsbf = 0;
  bit [7:0] m_w = 0, m_rx = 0, m_slv_rx = 0;
  bit       esck = 0, ess = 1, emosi = 0, ebusy = 0, edone = 0;
  bit [7:0] erdata = 0;
  bit [7:0] sb = 8'h00;
  bit       last_mosi = 0;
  bit       started = 0;
  bit       end_pending = 0;
  bit [7:0] end_w = 0, end_sb = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      chk(1'b0, "watchdog expired", cyc, WATCHDOG);
      report();
      $finish;
    end
    started = 1;
    if (rst) begin
      m_busy = 0; esck = cpol_i; ess = 1; emosi = 0; ebusy = 0; edone = 0; erdata = 0;
    end else begin
      edone = 0;
      if (!m_busy) begin
        esck = cpol_i;
        if (start_i) begin
          m_busy = 1; m_cnt = 0; m_s = 0; m_rx = 0; m_slv_rx = 0;
          m_sel = rate_sel_i; m_h = 1 << rate_sel_i;
          m_cpha = cpha_i; m_lsbf = lsb_first_i; m_w = wdata_i;
          ess = 0; ebusy = 1;
          emosi = m_cpha ? 1'b0 : m_w[bpos(0, m_lsbf)];
          m_oi  = m_cpha ? 0 : 1;
        end
      end else begin
        m_cnt++;
        if (m_cnt % m_h == 0) begin
          automatic int j = m_cnt / m_h;
          automatic bit odd = (j % 2) == 1;
          if (j <= 16) begin
            esck = ~esck;
            if (m_cpha ? !odd : odd) begin
              m_rx[bpos(m_s, m_lsbf)]     = miso_i;
              m_slv_rx[bpos(m_s, m_lsbf)] = last_mosi;
              m_s++;
            end
            if (m_cpha ? odd : (!odd && j != 16)) begin
              emosi = m_w[bpos(m_oi, m_lsbf)];
              m_oi++;
            end
          end
          if (j == 17) begin
            ess = 1; edone = 1; emosi = 0; erdata = m_rx;
            end_pending = 1; end_w = m_w; end_sb = sb;
          end
          if (j == 18) begin
            m_busy = 0; ebusy = 0;
          end
        end
      end
    end
  end

  // per-cycle comparison and slave model
  int  blen = 0, gap = 0;
  bit  prev_busy = 0, prev_ss = 1, had_xfer = 0;
  int  gap_sel = 0;

  always @(negedge clk) begin
    if (started) begin
      chk(sck_o == esck,     "R4 sck level",  sck_o,   esck);
      chk(mosi_o == emosi,   "R5 mosi",       mosi_o,  emosi);
      chk(ss_n_o == ess,     "R7 ss_n",       ss_n_o,  ess);
      chk(busy_o == ebusy,   "R9 busy",       busy_o,  ebusy);
      chk(done_o == edone,   "R11 done",      done_o,  edone);
      chk(rdata_o == erdata, "R11 rdata",     rdata_o, erdata);
      if (!busy_o) chk(mosi_o == 1'b0, "R13 mosi idle low", mosi_o, 0);
      if (end_pending) begin
        end_pending = 0;
        chk(rdata_o == end_sb, "R3 received byte", rdata_o, end_sb);
        chk(m_slv_rx == end_w, "R6 slave got written byte", m_slv_rx, end_w);
        gap_sel = m_sel;
      end
      if (busy_o) blen++;
      if (prev_busy && !busy_o) begin
        chk(blen == (18 << m_sel), "R2 busy length", blen, 18 << m_sel);
        blen = 0;
        had_xfer = 1;
      end
      if (ss_n_o) gap++;
      if (prev_ss && !ss_n_o) begin
        if (had_xfer) chk(gap >= (1 << gap_sel), "R8 deselect gap", gap, 1 << gap_sel);
        gap = 0;
      end
      prev_busy = busy_o;
      prev_ss   = ss_n_o;
    end
    last_mosi = mosi_o;
    miso_i    = (m_busy && m_s < 8) ? sb[bpos(m_s, m_lsbf)] : 1'b0;
  end

  task automatic xfer(input bit [7:0] w, input bit [7:0] s, input int sel,
                      input bit pol, input bit pha, input bit lsbf);
    @(negedge clk);
    sb = s; wdata_i = w; rate_sel_i = 3'(sel);
    cpol_i = pol; cpha_i = pha; lsb_first_i = lsbf; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk(rdata_o == s, "R3 rdata after exchange", rdata_o, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(sck_o == 1'b0 && ss_n_o && !mosi_o && !busy_o && !done_o && rdata_o == 8'h00,
        "R12 reset state", {sck_o, ss_n_o, mosi_o, busy_o, done_o}, 5'b01000);
    cpol_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sck_o == 1'b1, "R4 idle follows cpol", sck_o, 1);

    xfer(8'hA5, 8'h3C, 0, 0, 0, 0);   // R1 fastest rate, mode 0
    xfer(8'h81, 8'hC6, 1, 1, 0, 1);   // R6 lsb first, idle high
    xfer(8'h5E, 8'h96, 2, 0, 1, 0);   // R5 cpha=1
    xfer(8'h0F, 8'hF1, 0, 1, 1, 1);   // R5 mode 3, lsb first

    // R9 and R10: start pulses and mode changes during an exchange
    @(negedge clk);
    sb = 8'h69; wdata_i = 8'hD2; rate_sel_i = 3'd3;
    cpol_i = 0; cpha_i = 0; lsb_first_i = 0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    wdata_i = 8'h11; rate_sel_i = 3'd0; cpol_i = 1; cpha_i = 1; lsb_first_i = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk(rdata_o == 8'h69, "R10 rdata unaffected by mid changes", rdata_o, 8'h69);
    @(negedge clk);
    chk(!busy_o && ss_n_o, "R9 no queued exchange", busy_o, 0);

    xfer(8'h3B, 8'hE4, 7, 0, 1, 1);   // R1 slowest rate

    // R8 back-to-back with start held high
    @(negedge clk);
    sb = 8'h55; wdata_i = 8'hAA; rate_sel_i = 3'd1;
    cpol_i = 0; cpha_i = 0; lsb_first_i = 0; start_i = 1'b1;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(busy_o && !ss_n_o, "R8 restart after gap", busy_o, 1);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);

    report();
    $finish;
  end

endmodule